// File: doc/BRIEF.md
# Sliding-Window Moving Average Filter

This block is a streaming datapath that smooths a sequence of signed integer samples. Every sample presented with its valid strobe is taken into a short history. In the next clock the block reports the mean of that sample and the samples that came just before it, with one window of `L` samples in all. The sample width and the window length are compile-time parameters. `L` must be a power of two and at least 2, so dividing by `L` is a right shift.

The window sum is formed directly from the stored history by one adder chain over all `L` operands; no running total is carried between samples. The sum register is wide enough that `L` full-scale samples cannot overflow it. The fractional part of the mean is dropped by rounding toward negative infinity. Until `L` samples have been taken since reset, the missing older samples count as zero, so the output ramps up from zero. Cycles without a valid sample leave the history and the output untouched. An active-high synchronous reset empties the window.

Top module: `movavg_window`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `out_valid` is 0 and `out_avg` is 0.
- R2: `out_valid` is high for exactly the one clock that follows each clock in which `in_valid` was high, and low in every other clock.
- R3: Each result equals floor(S / L), where S is the exact sum of the accepted sample and the L-1 samples accepted before it. Samples and results are two's complement, `WIDTH` bits wide.
- R4: Samples older than the first one accepted after reset count as zero. With L = 8, a first sample of 0x67B gives 0xCF, and a second sample of 0x683 then gives 0x19F.
- R5: A negative window sum rounds toward negative infinity. With L = 8 and an empty window, a sample of -1 gives -1 (all ones). A following sample of -9 then gives -2.
- R6: In a clock where `in_valid` is low, `out_avg` keeps its value and the history is not shifted.
- R7: The sum cannot overflow. L samples of the largest positive value give that value back, and L samples of the most negative value give that value back.
- R8: A reset in the middle of a stream restarts averaging from an all-zero window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | WIDTH | Signed input sample |
| out_valid | output | 1 | High for one clock when `out_avg` holds a new mean |
| out_avg | output | WIDTH | Signed window mean, rounded toward negative infinity; held between results |

## Verification
Suppose a history entry is lost, duplicated or shifted when no sample arrived. Then the next result is off from the scoreboard value, and the error stays in the results until that entry leaves the window, which takes up to L-1 further samples. A history that is not cleared shows in the first result after reset, one clock after the first accepted sample. A wrong valid pipeline or a drifting held output is caught in the very next clock, because the monitor compares `out_valid` and the held `out_avg` on every cycle. Full-scale and negative windows exercise the carry width and the rounding direction.

// File: rtl/movavg_window.sv
module movavg_window #(
  parameter int WIDTH = 32,
  parameter int L     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [WIDTH-1:0] in_sample,
  output logic                    out_valid,
  output logic signed [WIDTH-1:0] out_avg
);
  localparam int SHIFT = $clog2(L);
  localparam int SUM_W = WIDTH + SHIFT;
  localparam int TAPS  = L - 1;

  logic signed [WIDTH-1:0] taps_q [TAPS];
  logic signed [SUM_W-1:0] win_sum;
  logic signed [SUM_W-1:0] sum_q;

  always_comb begin
    win_sum = SUM_W'(in_sample);
    for (int i = 0; i < TAPS; i++)
      win_sum = win_sum + SUM_W'(taps_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) taps_q[i] <= '0;
      sum_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taps_q[0] <= in_sample;
        for (int i = 1; i < TAPS; i++) taps_q[i] <= taps_q[i-1];
        sum_q <= win_sum;
      end
    end
  end

  // dropping the low SHIFT bits of a two's complement sum floors the quotient
  assign out_avg = sum_q[SUM_W-1:SHIFT];
endmodule

// File: rtl/movavg_window_chk.sv
module movavg_window_chk #(
  parameter int WIDTH = 32,
  parameter int L     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_sample,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_avg
);
  localparam int SHIFT = $clog2(L);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_avg == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_only_after_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_avg));

  assert_first_sample_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && in_valid) |=>
      ($signed(out_avg) == ($signed($past(in_sample)) >>> SHIFT)));
endmodule

bind movavg_window movavg_window_chk #(.WIDTH(WIDTH), .L(L)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_avg(out_avg)
);

// File: tb/movavg_window_test.sv
module movavg_window_test;
  localparam int W = 32;
  localparam int L = 8;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic                out_valid;
  logic signed [W-1:0] out_avg;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  longint       hist_m [$];
  logic [W-1:0] last_exp = '0;

  always #5 clk = ~clk;

  movavg_window #(.WIDTH(W), .L(L)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_avg(out_avg)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic signed [W-1:0] x, input string tag);
    longint s, q;
    s = longint'(x);
    foreach (hist_m[i]) s += hist_m[i];
    q = s / L;
    if (s < 0 && (s % L) != 0) q = q - 1;
    hist_m.push_front(longint'(x));
    if (hist_m.size() > L - 1) void'(hist_m.pop_back());
    exp_q.push_back(q[W-1:0]);
    tag_q.push_back(tag);
    in_valid  = 1'b1;
    in_sample = x;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    hist_m.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    bit pv, pr;
    forever begin
      @(posedge clk);
      pv = in_valid;
      pr = rst;
      @(negedge clk);
      if (pr) begin
        check(!out_valid && out_avg == '0, "R1/R8 reset state",
              {out_avg[W-1:1], out_valid}, '0);
        last_exp = '0;
      end else begin
        check(out_valid == pv, "R2 valid timing", W'(out_valid), W'(pv));
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected result", out_avg, 'x);
          end else begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_avg == e, t, out_avg, e);
            last_exp = e;
          end
        end else begin
          check(out_avg == last_exp, "R6 hold while idle", out_avg, last_exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);

    // R4: ramp-up from an empty window
    send(32'sh67B, "R4 first sample");
    send(32'sh683, "R4 second sample");
    idle(3);

    // R3: small ramp with gaps, partial and full window
    do_reset();
    for (int v = 2; v <= 12; v++) begin
      send(W'(v), "R3 ramp");
      if (v % 4 == 0) idle(2);
    end
    idle(3);

    // R5: negative rounding
    do_reset();
    send(-32'sd1, "R5 minus one");
    send(-32'sd9, "R5 minus nine");
    send(32'sd3, "R5 mixed");
    idle(3);

    // R7: full-scale windows
    do_reset();
    for (int i = 0; i < L; i++) send(32'sh7FFFFFFF, "R7 max positive");
    for (int i = 0; i < L; i++) send(32'sh80000000, "R7 most negative");
    idle(3);

    // R8: reset in mid-stream
    send(32'sd1000, "R8 before reset");
    send(32'sd2000, "R8 before reset");
    idle(2);
    do_reset();
    send(32'sd80, "R8 after reset");
    idle(2);

    // R3/R6: random signed samples from 16-bit data with random gaps
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      send(W'($signed(r[15:0])), "R3 random window");
      if (($urandom % 3) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);

    check(exp_q.size() == 0, "R2 results outstanding", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule